// File: doc/BRIEF.md
# Eight-Line GPIO Bank with Edge Interrupts

This block gives software control over eight general-purpose pins through a small file of byte-wide registers. Each pin can be an input or a driven output, and can have its sensed level inverted. A pin can also be handed to an alternate function, where its level is passed on as a counter input. Incoming pin levels are synchronised to the block clock and then go through the per-line inversion. The adjusted level is what software reads back, and it is also what the transition detector watches.

A low-to-high step of the adjusted level on a line in GPIO mode sets a sticky status bit. Software clears that bit by writing a one to it. Status bits that are not masked are OR-ed into a single interrupt request, which a global enable qualifies. A 3-bit selector in the same control register chooses which system IRQ number the request is reported under. The register port is a plain single-cycle write strobe with a combinational read. It never stalls, so there is no back-pressure. Pad cells and the serial interrupt encoder sit outside the block.

Top module: `gpio_bank`

## Requirements
- R1: While reset is low, and right after it is released, every register reads 0. pin_oe and pin_out are 0, irq_req is 0, irq_num is 3, and every line is in GPIO mode.
- R2: The register offsets are 0 direction, 1 inversion, 2 output value, 3 input value, 4 mask, 5 status, 6 control and 7 mode. Offsets 0, 1, 2, 4 and 7 read back the last value written. Control reads back bits 7:4 as written and bits 3:0 as 0. A write to offset 3 has no effect.
- R3: pin_oe[i] is 1 only when direction bit i is 1 and mode bit i is 0. pin_out equals the output value register, with no inversion. pin_out changes only in the cycle after a write to offset 2.
- R4: Offset 3 reads pin_in XOR the inversion register. The synchroniser has two stages, so a pin change made before clock edge k is seen after edge k+1. A change to the inversion register is seen at once.
- R5: Status bit i sets on the edge after the adjusted level of line i is first seen going 0 to 1 while mode bit i is 0. A change of inversion that raises the adjusted level counts as such a step. Once set, the bit stays set.
- R6: Writing offset 5 clears each status bit whose data bit is 1 and leaves the others unchanged. If a new rising step arrives in the same cycle as the clearing write, the bit stays set.
- R7: irq_req is control bit 7 AND the OR of (status AND mask). It follows register changes in the same cycle and does not drop without a register write.
- R8: Control bits 6:4 select irq_num: 0→3, 1→4, 2→5, 3→10, 4→6, 5→7, 6→9, 7→11.
- R9: With mode bit i at 1, alt_in[i] carries the adjusted level of line i, the line is never driven, and its status bit never sets. With mode bit i at 0, alt_in[i] is 0.
- R10: A 1-to-0 step of the adjusted level leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 3 | Register offset for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| pin_in | input | N_LINES | Raw pin levels from the pads |
| pin_out | output | N_LINES | Output levels to the pads |
| pin_oe | output | N_LINES | Per-line drive enable, 1 = drive |
| alt_in | output | N_LINES | Adjusted levels of lines in alternate mode |
| irq_req | output | 1 | Combined interrupt request |
| irq_num | output | 4 | IRQ number chosen by the selector |

## Verification
The hardest case to reach from the ports is a rising step landing in exactly the cycle in which software writes a one to clear the same status bit. The step has to be lined up with the two-stage synchroniser. The stimulus therefore changes the pin two edges before it issues the clearing write, so the set and the clear meet at the same edge. Steps caused only by rewriting the inversion register get the same treatment. A long random phase mixes pin toggles with writes to every offset, and a behavioural reference model compares all outputs on every cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 3'd0,
    REG_POL  = 3'd1,
    REG_OUT  = 3'd2,
    REG_IN   = 3'd3,
    REG_MASK = 3'd4,
    REG_STAT = 3'd5,
    REG_CTRL = 3'd6,
    REG_MODE = 3'd7
  } reg_addr_e;

  function automatic logic [3:0] irq_code_to_num(input logic [2:0] code);
    logic [3:0] n;
    case (code)
      3'd0: n = 4'd3;
      3'd1: n = 4'd4;
      3'd2: n = 4'd5;
      3'd3: n = 4'd10;
      3'd4: n = 4'd6;
      3'd5: n = 4'd7;
      3'd6: n = 4'd9;
      default: n = 4'd11;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_cell.sv
module gpio_edge_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic arm,
  input  logic clr,
  output logic stat
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      stat <= 1'b0;
    end else begin
      prev <= lvl;
      stat <= (lvl & ~prev & arm) | (stat & ~clr);
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [N_LINES-1:0] in_val,
  input  logic [N_LINES-1:0] stat_q,
  output logic [N_LINES-1:0] dir_q,
  output logic [N_LINES-1:0] pol_q,
  output logic [N_LINES-1:0] out_q,
  output logic [N_LINES-1:0] mask_q,
  output logic [N_LINES-1:0] mode_q,
  output logic               irq_en,
  output logic [2:0]         irq_sel,
  output logic [N_LINES-1:0] stat_clr
);
  reg_addr_e addr;
  assign addr = reg_addr_e'(reg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      pol_q   <= '0;
      out_q   <= '0;
      mask_q  <= '0;
      mode_q  <= '0;
      irq_en  <= 1'b0;
      irq_sel <= '0;
    end else if (reg_we) begin
      case (addr)
        REG_DIR:  dir_q  <= reg_wdata[N_LINES-1:0];
        REG_POL:  pol_q  <= reg_wdata[N_LINES-1:0];
        REG_OUT:  out_q  <= reg_wdata[N_LINES-1:0];
        REG_MASK: mask_q <= reg_wdata[N_LINES-1:0];
        REG_MODE: mode_q <= reg_wdata[N_LINES-1:0];
        REG_CTRL: begin
          irq_en  <= reg_wdata[7];
          irq_sel <= reg_wdata[6:4];
        end
        default: ;
      endcase
    end
  end

  assign stat_clr = (reg_we && addr == REG_STAT) ? reg_wdata[N_LINES-1:0] : '0;

  always_comb begin
    reg_rdata = '0;
    case (addr)
      REG_DIR:  reg_rdata[N_LINES-1:0] = dir_q;
      REG_POL:  reg_rdata[N_LINES-1:0] = pol_q;
      REG_OUT:  reg_rdata[N_LINES-1:0] = out_q;
      REG_IN:   reg_rdata[N_LINES-1:0] = in_val;
      REG_MASK: reg_rdata[N_LINES-1:0] = mask_q;
      REG_STAT: reg_rdata[N_LINES-1:0] = stat_q;
      REG_CTRL: reg_rdata = {irq_en, irq_sel, 4'b0000};
      REG_MODE: reg_rdata[N_LINES-1:0] = mode_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int N_LINES     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic [N_LINES-1:0] pin_in,
  output logic [N_LINES-1:0] pin_out,
  output logic [N_LINES-1:0] pin_oe,
  output logic [N_LINES-1:0] alt_in,
  output logic               irq_req,
  output logic [3:0]         irq_num
);
  logic [N_LINES-1:0] sync_q, lvl;
  logic [N_LINES-1:0] dir_q, pol_q, out_q, mask_q, mode_q;
  logic [N_LINES-1:0] stat_q, stat_clr;
  logic               irq_en;
  logic [2:0]         irq_sel;

  gpio_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );

  assign lvl = sync_q ^ pol_q;

  gpio_regs #(.N_LINES(N_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .in_val(lvl), .stat_q(stat_q),
    .dir_q(dir_q), .pol_q(pol_q), .out_q(out_q), .mask_q(mask_q),
    .mode_q(mode_q), .irq_en(irq_en), .irq_sel(irq_sel),
    .stat_clr(stat_clr)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    gpio_edge_cell u_edge (
      .clk(clk), .rst_n(rst_n),
      .lvl(lvl[i]), .arm(~mode_q[i]), .clr(stat_clr[i]),
      .stat(stat_q[i])
    );
    assign pin_oe[i] = dir_q[i] & ~mode_q[i];
    assign alt_in[i] = lvl[i] & mode_q[i];
  end

  assign pin_out = out_q;
  assign irq_req = irq_en & |(stat_q & mask_q);
  assign irq_num = irq_code_to_num(irq_sel);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int N_LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic [2:0]         reg_addr,
  input logic [N_LINES-1:0] pin_out,
  input logic               irq_req,
  input logic [3:0]         irq_num,
  input logic [N_LINES-1:0] stat_q,
  input logic [N_LINES-1:0] lvl,
  input logic [N_LINES-1:0] mode_q
);
  // R6: without a status write, no set status bit is lost
  a_r6_sticky_status: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 3'd5) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R7: the request cannot fall unless a register is written
  a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !reg_we) |=> irq_req);

  // R3: pin_out moves only after an output-register write
  a_r3_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 3'd2) |=> $stable(pin_out));

  // R5 / R9 / R10: a newly set status bit needs a prior rise on a GPIO-mode line
  a_r5_set_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q)) & ~($past(lvl) & ~$past(lvl, 2) & ~$past(mode_q))) == '0);

  // R8: only the eight legal IRQ numbers appear
  a_r8_irq_num_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq_num inside {4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd9, 4'd10, 4'd11});
endmodule

bind gpio_bank gpio_bank_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .pin_out(pin_out), .irq_req(irq_req), .irq_num(irq_num),
  .stat_q(stat_q), .lvl(lvl), .mode_q(mode_q)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe, alt_in;
  logic       irq_req;
  logic [3:0] irq_num;

  always #2 clk = ~clk;

  gpio_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alt_in(alt_in),
    .irq_req(irq_req), .irq_num(irq_num)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Behavioural reference model
  logic [7:0] m_dir, m_pol, m_out, m_mask, m_mode, m_stat, m_prev;
  logic       m_en;
  logic [2:0] m_sel;
  logic [7:0] sq[$];

  function automatic logic [3:0] exp_num(input logic [2:0] c);
    logic [3:0] t[8] = '{4'd3, 4'd4, 4'd5, 4'd10, 4'd6, 4'd7, 4'd9, 4'd11};
    return t[c];
  endfunction

  function automatic logic [7:0] m_lvl();
    return sq[0] ^ m_pol;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_dir;
      3'd1: return m_pol;
      3'd2: return m_out;
      3'd3: return m_lvl();
      3'd4: return m_mask;
      3'd5: return m_stat;
      3'd6: return {m_en, m_sel, 4'b0000};
      default: return m_mode;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 0; m_pol = 0; m_out = 0; m_mask = 0; m_mode = 0;
      m_stat = 0; m_prev = 0; m_en = 0; m_sel = 0;
      sq = '{8'h00, 8'h00};
    end else begin
      logic [7:0] lv, rise, clr;
      lv   = m_lvl();
      rise = lv & ~m_prev & ~m_mode;
      clr  = (reg_we && reg_addr == 3'd5) ? reg_wdata : 8'h00;
      m_stat = (m_stat & ~clr) | rise;
      m_prev = lv;
      sq.push_back(pin_in);
      void'(sq.pop_front());
      if (reg_we) begin
        case (reg_addr)
          3'd0: m_dir  = reg_wdata;
          3'd1: m_pol  = reg_wdata;
          3'd2: m_out  = reg_wdata;
          3'd4: m_mask = reg_wdata;
          3'd6: begin m_en = reg_wdata[7]; m_sel = reg_wdata[6:4]; end
          3'd7: m_mode = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && sq.size() == 2) begin
      chk("R2 rdata",   reg_rdata, exp_rd(reg_addr));
      chk("R3 pin_out", pin_out, m_out);
      chk("R3 pin_oe",  pin_oe, m_dir & ~m_mode);
      chk("R9 alt_in",  alt_in, m_lvl() & m_mode);
      chk("R7 irq_req", irq_req, m_en & |(m_stat & m_mask));
      chk("R8 irq_num", irq_num, exp_num(m_sel));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a; #0.5;
    v = reg_rdata;
  endtask

  task automatic clear_all();
    wr(3'd0, 0); wr(3'd1, 0); wr(3'd2, 0); wr(3'd4, 0); wr(3'd6, 0); wr(3'd7, 0);
    pin_in = 0; idle(3); wr(3'd5, 8'hFF);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk); #1;
    // R1 during reset
    for (int a = 0; a < 8; a++) begin rd(3'(a), v); chk("R1 reg in reset", v, 0); end
    chk("R1 pin_oe", pin_oe, 0); chk("R1 pin_out", pin_out, 0);
    chk("R1 irq_req", irq_req, 0); chk("R1 irq_num", irq_num, 3);
    rst_n = 1'b1;
    idle(1);
    for (int a = 0; a < 8; a++) begin rd(3'(a), v); chk("R1 reg after reset", v, 0); end
    idle(1);

    // R2 register map readback
    wr(3'd0, 8'hA5); wr(3'd2, 8'h3C); wr(3'd4, 8'h96); wr(3'd7, 8'h18);
    wr(3'd6, 8'hFF); wr(3'd3, 8'hFF);
    rd(3'd0, v); chk("R2 dir", v, 8'hA5);
    rd(3'd2, v); chk("R2 out", v, 8'h3C);
    rd(3'd4, v); chk("R2 mask", v, 8'h96);
    rd(3'd7, v); chk("R2 mode", v, 8'h18);
    rd(3'd6, v); chk("R2 ctrl low nibble", v, 8'hF0);
    rd(3'd3, v); chk("R2 input ignores write", v, 8'h00);
    idle(1);
    clear_all();

    // R3 drive enables and output value
    wr(3'd0, 8'h0F); wr(3'd2, 8'h3C);
    chk("R3 oe", pin_oe, 8'h0F); chk("R3 out", pin_out, 8'h3C);
    wr(3'd7, 8'h01);
    chk("R3 oe alt forced", pin_oe, 8'h0E);
    clear_all();

    // R4 synchroniser latency and inversion
    pin_in = 8'h81;
    idle(1); rd(3'd3, v); chk("R4 after one edge", v, 8'h00);
    idle(1); rd(3'd3, v); chk("R4 after two edges", v, 8'h81);
    idle(1);
    wr(3'd1, 8'hF0); rd(3'd3, v); chk("R4 inverted", v, 8'h71);
    idle(1);
    clear_all();

    // R5 / R7 rising step sets status, drives request
    pin_in = 8'h04;
    idle(2); rd(3'd5, v); chk("R5 not yet set", v, 8'h00);
    idle(1); rd(3'd5, v); chk("R5 set", v, 8'h04);
    idle(1);
    wr(3'd4, 8'h04); chk("R7 no enable", irq_req, 0);
    wr(3'd6, 8'h80); chk("R7 enabled", irq_req, 1);
    wr(3'd4, 8'h00); chk("R7 masked", irq_req, 0);
    wr(3'd4, 8'h04);
    // R10 falling step
    pin_in = 8'h00; idle(4); rd(3'd5, v); chk("R10 fall no effect", v, 8'h04);
    idle(1);
    // R6 write-one-to-clear
    wr(3'd5, 8'hFB); rd(3'd5, v); chk("R6 zero bit kept", v, 8'h04);
    idle(1);
    wr(3'd5, 8'h04); rd(3'd5, v); chk("R6 cleared", v, 8'h00);
    chk("R7 drops after clear", irq_req, 0);
    idle(1);
    // R6 set wins over simultaneous clear
    pin_in = 8'h20; idle(2);
    wr(3'd5, 8'h20); rd(3'd5, v); chk("R6 set beats clear", v, 8'h20);
    idle(1);
    // R5 inversion-induced rise
    wr(3'd5, 8'hFF); wr(3'd1, 8'h01); idle(1);
    rd(3'd5, v); chk("R5 rise from inversion", v, 8'h01);
    idle(1);
    clear_all();

    // R8 IRQ number mapping
    for (int c = 0; c < 8; c++) begin
      wr(3'd6, {1'b1, 3'(c), 4'b0000});
      chk("R8 irq map", irq_num, exp_num(3'(c)));
    end
    clear_all();

    // R9 alternate mode
    wr(3'd0, 8'h80); wr(3'd7, 8'h80);
    chk("R9 no drive", pin_oe, 8'h00);
    pin_in = 8'h81; idle(2);
    chk("R9 alt level", alt_in, 8'h80);
    idle(2); rd(3'd5, v); chk("R9 no status in alt", v, 8'h01);
    idle(1);
    clear_all();

    // Random mix checked by the model every cycle
    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 3) == 0) pin_in = 8'($urandom);
      if ($urandom_range(0, 2) == 0) wr(3'($urandom_range(0, 7)), 8'($urandom));
      else begin reg_addr = 3'($urandom_range(0, 7)); idle(1); end
    end

    summary();
    $finish;
  end
endmodule